// File: doc/BRIEF.md
# Segment-Buffered DRAM Device Front End

This block sits on the device side of a small DRAM core model. Between the cell array and the narrow external data port it places a set of wide segment buffers. Each buffer holds one whole row segment taken from any row and any segment position of the array. The host drives a command interface in the usual SDRAM style: row open (activate), row close (precharge), column read and column write. All column data traffic is served from the buffers, never from the array directly.

The command set is widened without adding any pins. Spare address bits carried on a column command choose one of the buffers and select one of two kinds of command:
- a plain word access;
- a whole-segment transfer between the array and a buffer. Fetching copies a segment of the open row into a buffer and records where it came from. Storing writes a buffer back to the row and segment it is tagged with.

A controller that leaves the selection bit clear behaves like a conventional SDRAM controller: all of its column accesses land in the default buffer.

Top module: `segbuf_fe`

## Requirements
- R1: After reset every buffer is invalid and no row is open, and `rvalid_o`, `err_o` and `rdata_o` are all zero.
- R2: An open command (`cmd_i`=1) opens the row in `addr_i[3:0]`. A close command (`cmd_i`=2) leaves no row open.
- R3: A read command (`cmd_i`=3) with `addr_i[10]`=1 and a row open is a fetch. It copies segment `addr_i[4:3]` of the open row into buffer `addr_i[8:5]` in one transfer, marks that buffer valid, and tags it with that row and segment.
- R4: A write command (`cmd_i`=4) with `addr_i[10]`=1 is a store. It copies the whole of buffer `addr_i[8:5]` into the array at its tagged row and segment, whether or not a row is open. A store from an invalid buffer writes nothing and raises `err_o`.
- R5: A read or write with `addr_i[10]`=0 and `addr_i[9]`=1 accesses word `addr_i[2:0]` of buffer `addr_i[8:5]`. A write stores `wdata_i` there.
- R6: A read or write with `addr_i[10]`=0 and `addr_i[9]`=0 uses buffer 0, whatever the value in `addr_i[8:5]`.
- R7: Each word read raises `rvalid_o` for one cycle, two cycles after the command, and presents its data on `rdata_o`. Reads issued back to back produce results back to back.
- R8: A word read or write to an invalid buffer raises `err_o` two cycles after the command. The read returns zero data, and the write leaves no trace.
- R9: A fetch issued while no row is open raises `err_o` two cycles later and leaves the target buffer unchanged.
- R10: Buffers are independent and fully associative. Any buffer may hold any row and segment, and an access or fetch on one buffer changes no other buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command: 0 idle, 1 open row, 2 close row, 3 read, 4 write |
| addr_i | input | 11 | Row on open; word, segment, buffer, select and transfer fields on read and write |
| wdata_i | input | 16 | Write data for a word write |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | 16 | Read data, zero when not valid or on error |
| err_o | output | 1 | Error pulse for a rejected command |

## Verification
The hardest case to reach is a store that lands on a row other than the open one. It only shows when a buffer's tag differs from the row open at the time of the store. The test never reads the array directly, so the data written by that store can only be seen by fetching it back into a different buffer later.

To reach it, the stimulus fills one buffer from one row and a second buffer from another row, writes a distinct pattern into each, and stores both. It then reopens each row in turn and fetches the segments into fresh buffers, so that a store sent to the wrong location would return the other buffer's pattern.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_OPEN,
    OP_CLOSE,
    OP_READ,
    OP_WRITE,
    OP_FETCH,
    OP_STORE
  } op_e;

endpackage

// File: rtl/segbuf_cmd_dec.sv
module segbuf_cmd_dec
  import segbuf_pkg::*;
#(
  parameter int ROW_W   = 4,
  parameter int SEG_W   = 2,
  parameter int COL_W   = 3,
  parameter int CH_W    = 4,
  parameter int ADDR_W  = 11,
  parameter int DEF_BUF = 0
) (
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [COL_W-1:0]  word_o,
  output logic [CH_W-1:0]   buf_o
);
  localparam int CH_LSB   = COL_W + SEG_W;
  localparam int SEL_BIT  = CH_LSB + CH_W;
  localparam int XFER_BIT = SEL_BIT + 1;

  logic xfer, sel;
  logic [CH_W-1:0] ch;

  assign xfer   = addr_i[XFER_BIT];
  assign sel    = addr_i[SEL_BIT];
  assign ch     = addr_i[CH_LSB +: CH_W];
  assign row_o  = addr_i[ROW_W-1:0];
  assign seg_o  = addr_i[COL_W +: SEG_W];
  assign word_o = addr_i[COL_W-1:0];

  // transfers always name their buffer; plain accesses fall back to default
  assign buf_o = (xfer || sel) ? ch : CH_W'(DEF_BUF);

  always_comb begin
    op_o = OP_NONE;
    unique case (cmd_i)
      CMD_ACT: op_o = OP_OPEN;
      CMD_PRE: op_o = OP_CLOSE;
      CMD_RD:  op_o = xfer ? OP_FETCH : OP_READ;
      CMD_WR:  op_o = xfer ? OP_STORE : OP_WRITE;
      default: op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/segbuf_core_array.sv
module segbuf_core_array #(
  parameter int ROW_W    = 4,
  parameter int SEG_W    = 2,
  parameter int SEG_BITS = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                open_i,
  input  logic                close_i,
  input  logic [ROW_W-1:0]    open_row_i,
  input  logic [SEG_W-1:0]    fetch_seg_i,
  output logic [SEG_BITS-1:0] fetch_data_o,
  output logic                row_open_o,
  output logic [ROW_W-1:0]    cur_row_o,
  input  logic                store_i,
  input  logic [ROW_W-1:0]    store_row_i,
  input  logic [SEG_W-1:0]    store_seg_i,
  input  logic [SEG_BITS-1:0] store_data_i
);
  localparam int ENTRIES = (1 << ROW_W) * (1 << SEG_W);
  localparam int IDX_W   = ROW_W + SEG_W;

  logic [SEG_BITS-1:0] cells_q [ENTRIES];
  logic                open_q;
  logic [ROW_W-1:0]    row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      row_q  <= open_row_i;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (store_i) cells_q[IDX_W'({store_row_i, store_seg_i})] <= store_data_i;
  end

  assign fetch_data_o = cells_q[IDX_W'({row_q, fetch_seg_i})];
  assign row_open_o   = open_q;
  assign cur_row_o    = row_q;
endmodule

// File: rtl/segbuf_buf_bank.sv
module segbuf_buf_bank #(
  parameter int NUM_BUF = 16,
  parameter int CH_W    = 4,
  parameter int ROW_W   = 4,
  parameter int SEG_W   = 2,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [CH_W-1:0]               buf_i,
  input  logic [COL_W-1:0]              word_i,
  input  logic                          fetch_i,
  input  logic [DATA_W*(1<<COL_W)-1:0]  fetch_data_i,
  input  logic [ROW_W-1:0]              fetch_row_i,
  input  logic [SEG_W-1:0]              fetch_seg_i,
  input  logic                          write_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic                          sel_valid_o,
  output logic [DATA_W-1:0]             sel_word_o,
  output logic [DATA_W*(1<<COL_W)-1:0]  sel_data_o,
  output logic [ROW_W-1:0]              sel_row_o,
  output logic [SEG_W-1:0]              sel_seg_o,
  output logic [NUM_BUF-1:0]            valid_o
);
  localparam int SEG_BITS = DATA_W * (1 << COL_W);

  logic [SEG_BITS-1:0] dat_all [NUM_BUF];
  logic [ROW_W-1:0]    row_all [NUM_BUF];
  logic [SEG_W-1:0]    seg_all [NUM_BUF];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic                hit;
    logic                vld_q;
    logic [ROW_W-1:0]    trow_q;
    logic [SEG_W-1:0]    tseg_q;
    logic [SEG_BITS-1:0] dat_q;

    assign hit = (buf_i == CH_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        trow_q <= '0;
        tseg_q <= '0;
      end else if (fetch_i && hit) begin
        vld_q  <= 1'b1;
        trow_q <= fetch_row_i;
        tseg_q <= fetch_seg_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (fetch_i && hit)      dat_q <= fetch_data_i;
      else if (write_i && hit) dat_q[word_i*DATA_W +: DATA_W] <= wdata_i;
    end

    assign valid_o[b] = vld_q;
    assign dat_all[b] = dat_q;
    assign row_all[b] = trow_q;
    assign seg_all[b] = tseg_q;
  end

  assign sel_valid_o = valid_o[buf_i];
  assign sel_data_o  = dat_all[buf_i];
  assign sel_row_o   = row_all[buf_i];
  assign sel_seg_o   = seg_all[buf_i];
  assign sel_word_o  = sel_data_o[word_i*DATA_W +: DATA_W];
endmodule

// File: rtl/segbuf_rd_pipe.sv
module segbuf_rd_pipe #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              err_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rvalid_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              s1_v_q, s1_e_q;
  logic [DATA_W-1:0] s1_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q   <= 1'b0;
      s1_e_q   <= 1'b0;
      s1_d_q   <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      s1_v_q   <= rd_i;
      s1_e_q   <= err_i;
      s1_d_q   <= (rd_i && !err_i) ? data_i : '0;
      rvalid_o <= s1_v_q;
      err_o    <= s1_e_q;
      rdata_o  <= s1_d_q;
    end
  end
endmodule

// File: rtl/segbuf_fe.sv
module segbuf_fe
  import segbuf_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ROW_W   = 4,
  parameter int SEG_W   = 2,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 16,
  parameter int DEF_BUF = 0,
  localparam int CH_W     = $clog2(NUM_BUF),
  localparam int XFER_BIT = COL_W + SEG_W + CH_W + 1,
  localparam int ADDR_W   = (XFER_BIT + 1 > ROW_W) ? XFER_BIT + 1 : ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam int SEG_BITS = DATA_W * (1 << COL_W);

  op_e                 op;
  logic [ROW_W-1:0]    dec_row;
  logic [SEG_W-1:0]    dec_seg;
  logic [COL_W-1:0]    dec_word;
  logic [CH_W-1:0]     dec_buf;
  logic                row_open;
  logic [ROW_W-1:0]    cur_row;
  logic [SEG_BITS-1:0] arr_seg;
  logic                sel_valid;
  logic [DATA_W-1:0]   sel_word;
  logic [SEG_BITS-1:0] sel_data;
  logic [ROW_W-1:0]    sel_row;
  logic [SEG_W-1:0]    sel_seg;
  logic [NUM_BUF-1:0]  buf_valid;
  logic                fetch_ok, store_ok, write_ok, is_read, cmd_err;

  segbuf_cmd_dec #(
    .ROW_W(ROW_W), .SEG_W(SEG_W), .COL_W(COL_W), .CH_W(CH_W),
    .ADDR_W(ADDR_W), .DEF_BUF(DEF_BUF)
  ) u_dec (
    .cmd_i(cmd_i), .addr_i(addr_i), .op_o(op), .row_o(dec_row),
    .seg_o(dec_seg), .word_o(dec_word), .buf_o(dec_buf)
  );

  assign is_read  = (op == OP_READ);
  assign fetch_ok = (op == OP_FETCH) && row_open;
  assign store_ok = (op == OP_STORE) && sel_valid;
  assign write_ok = (op == OP_WRITE) && sel_valid;
  assign cmd_err  = ((op == OP_READ || op == OP_WRITE || op == OP_STORE) && !sel_valid)
                  || ((op == OP_FETCH) && !row_open);

  segbuf_core_array #(
    .ROW_W(ROW_W), .SEG_W(SEG_W), .SEG_BITS(SEG_BITS)
  ) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .open_i(op == OP_OPEN), .close_i(op == OP_CLOSE), .open_row_i(dec_row),
    .fetch_seg_i(dec_seg), .fetch_data_o(arr_seg),
    .row_open_o(row_open), .cur_row_o(cur_row),
    .store_i(store_ok), .store_row_i(sel_row), .store_seg_i(sel_seg),
    .store_data_i(sel_data)
  );

  segbuf_buf_bank #(
    .NUM_BUF(NUM_BUF), .CH_W(CH_W), .ROW_W(ROW_W), .SEG_W(SEG_W),
    .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .buf_i(dec_buf), .word_i(dec_word),
    .fetch_i(fetch_ok), .fetch_data_i(arr_seg), .fetch_row_i(cur_row),
    .fetch_seg_i(dec_seg), .write_i(write_ok), .wdata_i(wdata_i),
    .sel_valid_o(sel_valid), .sel_word_o(sel_word), .sel_data_o(sel_data),
    .sel_row_o(sel_row), .sel_seg_o(sel_seg), .valid_o(buf_valid)
  );

  segbuf_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(is_read), .err_i(cmd_err),
    .data_i(sel_word), .rvalid_o(rvalid_o), .err_o(err_o), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/segbuf_fe_chk.sv
module segbuf_fe_chk #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 16,
  parameter int NUM_BUF  = 16,
  parameter int CH_W     = 4,
  parameter int XFER_BIT = 10,
  parameter int CH_LSB   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              row_open,
  input logic [NUM_BUF-1:0] buf_valid
);
  logic [1:0] cyc_q;
  logic       rd_word, fetch_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  assign rd_word   = (cmd_i == 3'd3) && !addr_i[XFER_BIT];
  assign fetch_cmd = (cmd_i == 3'd3) &&  addr_i[XFER_BIT];

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!rvalid_o && !err_o && rdata_o == '0));

  a_r2_open_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 3'd1 |=> row_open);

  a_r2_close_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == 3'd2 |=> !row_open);

  a_r3_fetch_marks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_cmd && row_open) |=> buf_valid[$past(addr_i[CH_LSB +: CH_W])]);

  a_r7_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_word |-> ##2 rvalid_o);

  a_r7_no_stray_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && rvalid_o) |-> $past(rd_word, 2));

  a_r8_err_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && err_o) |-> rdata_o == '0);

  a_r9_fetch_closed_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_cmd && !row_open) |-> ##2 err_o);

  a_r9_fetch_closed_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_cmd && !row_open) |=> $stable(buf_valid));
endmodule

bind segbuf_fe segbuf_fe_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BUF(NUM_BUF), .CH_W(CH_W),
  .XFER_BIT(XFER_BIT), .CH_LSB(COL_W + SEG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .addr_i(addr_i),
  .rvalid_o(rvalid_o), .rdata_o(rdata_o), .err_o(err_o),
  .row_open(row_open), .buf_valid(buf_valid)
);

// File: tb/segbuf_fe_test.sv
module segbuf_fe_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        rv;
    logic        er;
    logic [15:0] d;
    string       req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic [10:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        rvalid_o, err_o;
  logic [15:0] rdata_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  exp_t q[$];

  logic [15:0] m_buf [16][8];
  logic [15:0] m_arr [16][4][8];
  bit          m_vld [16];
  logic [3:0]  m_trow [16];
  logic [1:0]  m_tseg [16];
  bit          m_open = 0;
  logic [3:0]  m_row = '0;

  segbuf_fe uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [10:0] mk(input bit xfer, input bit sel,
      input int ch, input int seg, input int word);
    return {xfer, sel, 4'(ch), 2'(seg), 3'(word)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
      input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit rv, input bit er, input logic [15:0] d, input string req);
    exp_t e;
    e.rv = rv; e.er = er; e.d = d; e.req = req;
    q.push_back(e);
  endtask

  // drive one command for one cycle, update the model, queue the expected result
  task automatic issue(input logic [2:0] c, input logic [10:0] a,
      input logic [15:0] wd, input string req);
    int ch, b;
    bit xfer, sel;
    xfer = a[10]; sel = a[9]; ch = int'(a[8:5]);
    b = (xfer || sel) ? ch : 0;
    case (c)
      3'd1: begin m_open = 1; m_row = a[3:0]; end
      3'd2: m_open = 0;
      3'd3: if (xfer) begin
              if (m_open) begin
                for (int w = 0; w < 8; w++) m_buf[ch][w] = m_arr[m_row][a[4:3]][w];
                m_vld[ch] = 1; m_trow[ch] = m_row; m_tseg[ch] = a[4:3];
              end else push(1'b0, 1'b1, 16'h0, req);
            end else begin
              if (m_vld[b]) push(1'b1, 1'b0, m_buf[b][a[2:0]], req);
              else          push(1'b1, 1'b1, 16'h0, req);
            end
      3'd4: if (xfer) begin
              if (m_vld[ch])
                for (int w = 0; w < 8; w++) m_arr[m_trow[ch]][m_tseg[ch]][w] = m_buf[ch][w];
              else push(1'b0, 1'b1, 16'h0, req);
            end else begin
              if (m_vld[b]) m_buf[b][a[2:0]] = wd;
              else          push(1'b0, 1'b1, 16'h0, req);
            end
      default: ;
    endcase
    cmd_i = c; addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    cmd_i = 3'd0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // monitor: compare every produced result with the queue head
  always @(negedge clk_i) begin
    if (rst_ni && (rvalid_o || err_o)) begin
      if (q.size() == 0) begin
        check(1'b0, "R7", "unexpected output", {14'h0, rvalid_o, err_o}, 16'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rvalid_o === e.rv && err_o === e.er && rdata_o === e.d, e.req,
              $sformatf("rv/err=%b%b data", rvalid_o, err_o), rdata_o, e.d);
        if (!(rvalid_o === e.rv && err_o === e.er))
          $display("  (%s expected rv/err=%b%b)", e.req, e.rv, e.er);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
    idle(3);
    check(rvalid_o === 1'b0 && err_o === 1'b0, "R1", "outputs in reset",
          {14'h0, rvalid_o, err_o}, 16'h0);
    rst_ni = 1'b1;
    idle(2);
    check(rdata_o === 16'h0 && !rvalid_o && !err_o, "R1", "rdata after reset", rdata_o, 16'h0);

    // R1/R8: default and selected buffers start invalid
    issue(3'd3, mk(0, 0, 0, 0, 2), 16'h0, "R1");
    issue(3'd3, mk(0, 1, 9, 0, 5), 16'h0, "R8");
    issue(3'd4, mk(0, 1, 9, 0, 5), 16'hbeef, "R8");
    // R9/R2: fetch with no row open
    issue(3'd3, mk(1, 0, 4, 1, 0), 16'h0, "R9");
    issue(3'd3, mk(0, 1, 4, 0, 0), 16'h0, "R9");
    idle(4);

    // R3/R5: fetch row 5 seg 2 into buffer 3, fill, read back
    issue(3'd1, 11'd5, 16'h0, "R2");
    issue(3'd3, mk(1, 0, 3, 2, 0), 16'h0, "R3");
    for (int w = 0; w < 8; w++) issue(3'd4, mk(0, 1, 3, 0, w), 16'ha000 + 16'(w), "R5");
    for (int w = 0; w < 8; w++) issue(3'd3, mk(0, 1, 3, 0, w), 16'h0, "R5");
    idle(3);

    // R7: exact latency of a single read
    issue(3'd3, mk(0, 1, 3, 0, 6), 16'h0, "R7");
    check(rvalid_o === 1'b0, "R7", "rvalid one cycle after", {15'h0, rvalid_o}, 16'h0);
    @(negedge clk_i);
    check(rvalid_o === 1'b1 && rdata_o === 16'ha006, "R7", "data two cycles after", rdata_o, 16'ha006);
    idle(2);

    // R4/R3/R10: store buffer 3, refetch into buffer 7, buffers independent
    issue(3'd4, mk(1, 0, 3, 0, 0), 16'h0, "R4");
    issue(3'd3, mk(1, 0, 7, 2, 0), 16'h0, "R3");
    issue(3'd3, mk(0, 1, 7, 0, 1), 16'h0, "R3");
    issue(3'd3, mk(0, 1, 7, 0, 7), 16'h0, "R3");
    issue(3'd4, mk(0, 1, 7, 0, 0), 16'h5555, "R10");
    issue(3'd3, mk(0, 1, 3, 0, 0), 16'h0, "R10");
    issue(3'd3, mk(0, 1, 7, 0, 0), 16'h0, "R10");
    issue(3'd4, mk(1, 0, 10, 0, 0), 16'h0, "R4");
    idle(4);

    // R6: legacy accesses use buffer 0 regardless of channel bits
    issue(3'd3, mk(1, 0, 0, 2, 0), 16'h0, "R6");
    issue(3'd3, mk(0, 0, 9, 0, 3), 16'h0, "R6");
    issue(3'd4, mk(0, 0, 12, 0, 4), 16'h1234, "R6");
    issue(3'd3, mk(0, 1, 0, 0, 4), 16'h0, "R6");
    issue(3'd3, mk(0, 1, 12, 0, 4), 16'h0, "R6");
    idle(4);

    // R2/R9: close then fetch fails, buffer 5 stays invalid
    issue(3'd2, 11'd0, 16'h0, "R2");
    issue(3'd3, mk(1, 0, 5, 1, 0), 16'h0, "R2");
    issue(3'd3, mk(0, 1, 5, 0, 0), 16'h0, "R9");
    idle(4);

    // R4/R10: store goes to the tag, not to the open row
    for (int w = 0; w < 8; w++) issue(3'd4, mk(0, 1, 7, 0, w), 16'hc700 + 16'(w), "R4");
    issue(3'd1, 11'd9, 16'h0, "R2");
    issue(3'd3, mk(1, 0, 2, 1, 0), 16'h0, "R10");
    for (int w = 0; w < 8; w++) issue(3'd4, mk(0, 1, 2, 0, w), 16'h9100 + 16'(w), "R10");
    issue(3'd4, mk(1, 0, 7, 0, 0), 16'h0, "R4");
    issue(3'd4, mk(1, 0, 2, 0, 0), 16'h0, "R4");
    issue(3'd1, 11'd5, 16'h0, "R2");
    issue(3'd3, mk(1, 0, 12, 2, 0), 16'h0, "R4");
    issue(3'd1, 11'd9, 16'h0, "R2");
    issue(3'd3, mk(1, 0, 15, 1, 0), 16'h0, "R4");
    for (int w = 0; w < 8; w++) begin
      issue(3'd3, mk(0, 1, 12, 0, w), 16'h0, "R4");
      issue(3'd3, mk(0, 1, 15, 0, w), 16'h0, "R10");
    end
    idle(5);

    check(q.size() == 0, "R7", "results outstanding", 16'(q.size()), 16'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule